// File: doc/BRIEF.md
# ADC Start-Convert Clock Gate

This controller sits between a free-running oscillator and the master clock pin of a sampling A/D converter. It halves the oscillator rate to produce the converter clock. Each time the converter signals the end of a conversion, the controller stops that clock. The converter is then held in its high-slew coarse tracking phase. A front end whose input moves in steps can settle during this hold without the converter sitting in its slower fine-tracking phase.

A single active-low start-convert input releases the clock. The converter then runs through coarse tracking, fine tracking and one conversion, with its hold input tied to its own end-of-track output. When it reports the end of that conversion, the controller freezes the clock again. The result is valid, and data-ready is high, from that point until the next start command. If start-convert is held low, as it must be during calibration, the clock runs without stopping. A two-bit status output reports whether the converter is locked, tracking or converting.

Top module: `adc_start_gate`

## Requirements
- R1: While the gate is not locked, `adc_clk` toggles on every rising edge of `osc_clk`, so one converter clock period equals two oscillator periods.
- R2: With `start_n` high, a falling edge of `adc_eoc` (seen as high in one oscillator cycle and low in the next) locks the gate. From then on `adc_clk` stays low and shows no edges until a start command.
- R3: While locked, `data_rdy` is 1 and `track_phase` reads 2'b00 (locked in coarse tracking).
- R4: A low level on `start_n` clears the lock on the next oscillator edge. `data_rdy` falls with it, and the first rising edge of `adc_clk` follows one oscillator cycle later.
- R5: A start pulse shorter than a conversion releases exactly one conversion. The clock runs until the next falling edge of `adc_eoc`, then stays stopped while `start_n` is high.
- R6: While `start_n` is held low (calibration), falling edges of `adc_eoc` do not lock the gate. The clock keeps toggling every oscillator cycle and `data_rdy` stays 0.
- R7: Every high pulse of `adc_clk` lasts exactly one oscillator period. The clock only ever stops at its low level, so no runt high pulse occurs.
- R8: A synchronous active-low reset drives `adc_clk` and `data_rdy` to 0 and clears the lock, even when it arrives while locked. `track_phase` reads 2'b01, and the clock runs once reset is released.
- R9: After a release, `track_phase` reads 2'b01 (tracking) until COARSE_CYC+FINE_CYC (default 6+9=15) rising edges of `adc_clk` have been counted. It reads 2'b10 (converting) from the oscillator cycle after that edge until the gate locks again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| osc_clk | input | 1 | Oscillator at twice the converter clock rate |
| rst_n | input | 1 | Synchronous active-low reset |
| start_n | input | 1 | Active-low start-convert; hold low for calibration |
| adc_eoc | input | 1 | End-of-conversion flag from the converter; its falling edge locks the gate |
| adc_clk | output | 1 | Gated master clock to the converter |
| data_rdy | output | 1 | High from end of conversion until the next start command |
| track_phase | output | 2 | 00 locked-coarse, 01 tracking, 10 converting |

## Verification
The bench first checks that, once locked, the clock produces no edge at all. A design that gated the clock while it was high would leave the converter clock stuck high or cut a high pulse short; the pulse-width monitor catches both. A held-low start input during calibration must keep the clock free-running through several end-of-conversion falls. A design that let those falls set the lock would freeze the clock and raise data-ready. The phase status is sampled just before and just after the 15th counted clock edge, which catches an off-by-one in the tracking count. A final reset applied while locked shows whether reset really clears the lock and restarts the clock.

// File: rtl/adc_gate_pkg.sv
// Shared types for the ADC start-convert clock gate.
// Assumes nothing beyond a two-bit phase encoding visible at the top ports.
package adc_gate_pkg;
    typedef enum logic [1:0] {
        PH_LOCKED = 2'b00,
        PH_TRACK  = 2'b01,
        PH_CONV   = 2'b10
    } phase_e;
endpackage

// File: rtl/agc_clk_divider.sv
// Divide-by-two clock generator with low-level gating.
// Toggles every oscillator edge unless a hold is requested; a hold only
// takes effect once the output is low, so a high phase always completes.
// Assumes hold_req is synchronous to osc_clk.
module agc_clk_divider (
    input  logic osc_clk,
    input  logic rst_n,
    input  logic hold_req,
    output logic div_clk
);
    logic div_q;

    // Divider flop: toggle when running, or to finish a high phase.
    always_ff @(posedge osc_clk) begin
        if (!rst_n)
            div_q <= 1'b0;
        else if (!hold_req || div_q)
            div_q <= ~div_q;
    end

    assign div_clk = div_q;

    // R2
    hold_low_chk: assert property (@(posedge osc_clk) disable iff (!rst_n)
        (hold_req && !div_clk) |=> !div_clk);

    // R7
    no_runt_chk: assert property (@(posedge osc_clk) disable iff (!rst_n)
        $rose(div_clk) |=> $fell(div_clk));
endmodule

// File: rtl/agc_lock_ctrl.sv
// Lock state for the clock gate.
// Detects a falling edge of the end-of-conversion flag and sets the lock;
// a low start input clears it and keeps it clear while low.
// Assumes adc_eoc changes only right after osc_clk edges (it is produced
// from the divided clock).
module agc_lock_ctrl (
    input  logic osc_clk,
    input  logic rst_n,
    input  logic start_n,
    input  logic adc_eoc,
    output logic locked
);
    logic eoc_q;
    logic eoc_fall;

    // Previous end-of-conversion level for edge detection.
    always_ff @(posedge osc_clk) begin
        if (!rst_n)
            eoc_q <= 1'b0;
        else
            eoc_q <= adc_eoc;
    end

    assign eoc_fall = eoc_q && !adc_eoc;

    // Lock flop: start has priority over a new end of conversion.
    always_ff @(posedge osc_clk) begin
        if (!rst_n)
            locked <= 1'b0;
        else if (!start_n)
            locked <= 1'b0;
        else if (eoc_fall)
            locked <= 1'b1;
    end

    // R4
    start_clears_chk: assert property (@(posedge osc_clk) disable iff (!rst_n)
        !start_n |=> !locked);

    // R2
    eoc_locks_chk: assert property (@(posedge osc_clk) disable iff (!rst_n)
        (start_n && $past(rst_n) && $fell(adc_eoc)) |=> locked);
endmodule

// File: rtl/agc_phase_tracker.sv
// Phase status from a count of converter clock rising edges since release.
// Reports locked while the gate is locked, tracking until the coarse plus
// fine cycle count is reached, and converting afterwards.
// Assumes div_clk toggles at most once per osc_clk edge.
module agc_phase_tracker
    import adc_gate_pkg::*;
#(
    parameter int COARSE_CYC = 6,
    parameter int FINE_CYC   = 9
) (
    input  logic   osc_clk,
    input  logic   rst_n,
    input  logic   locked,
    input  logic   div_clk,
    output phase_e phase_o
);
    localparam int TRACK_CYC = COARSE_CYC + FINE_CYC;
    localparam int CNT_W     = $clog2(TRACK_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(TRACK_CYC);

    logic             div_prev;
    logic             div_rise;
    logic [CNT_W-1:0] edge_cnt;

    // Previous divider level for rising-edge detection.
    always_ff @(posedge osc_clk) begin
        if (!rst_n)
            div_prev <= 1'b0;
        else
            div_prev <= div_clk;
    end

    assign div_rise = div_clk && !div_prev;

    // Saturating count of converter clock edges since release.
    always_ff @(posedge osc_clk) begin
        if (!rst_n || locked)
            edge_cnt <= '0;
        else if (div_rise && edge_cnt != CNT_MAX)
            edge_cnt <= edge_cnt + 1'b1;
    end

    // Status decode.
    always_comb begin
        if (locked)
            phase_o = PH_LOCKED;
        else if (edge_cnt == CNT_MAX)
            phase_o = PH_CONV;
        else
            phase_o = PH_TRACK;
    end

    // R9
    cnt_clear_chk: assert property (@(posedge osc_clk) disable iff (!rst_n)
        locked |=> edge_cnt == '0);

    // R9
    conv_sticky_chk: assert property (@(posedge osc_clk) disable iff (!rst_n)
        (phase_o == PH_CONV && !locked) |=> phase_o != PH_TRACK);
endmodule

// File: rtl/adc_start_gate.sv
// Top of the ADC start-convert clock gate.
// Divides the oscillator by two for the converter, stops that clock at its
// low level after each end of conversion, restarts it on start_n low, and
// reports data-ready and tracking phase.
// Assumes the converter's hold input is tied to its end-of-track output.
module adc_start_gate
    import adc_gate_pkg::*;
#(
    parameter int COARSE_CYC = 6,
    parameter int FINE_CYC   = 9
) (
    input  logic       osc_clk,
    input  logic       rst_n,
    input  logic       start_n,
    input  logic       adc_eoc,
    output logic       adc_clk,
    output logic       data_rdy,
    output logic [1:0] track_phase
);
    logic   locked;
    phase_e phase;

    agc_lock_ctrl i_lock (
        .osc_clk (osc_clk),
        .rst_n   (rst_n),
        .start_n (start_n),
        .adc_eoc (adc_eoc),
        .locked  (locked)
    );

    agc_clk_divider i_div (
        .osc_clk  (osc_clk),
        .rst_n    (rst_n),
        .hold_req (locked),
        .div_clk  (adc_clk)
    );

    agc_phase_tracker #(
        .COARSE_CYC (COARSE_CYC),
        .FINE_CYC   (FINE_CYC)
    ) i_phase (
        .osc_clk (osc_clk),
        .rst_n   (rst_n),
        .locked  (locked),
        .div_clk (adc_clk),
        .phase_o (phase)
    );

    assign data_rdy    = locked;
    assign track_phase = phase;

    // R3
    rdy_locked_chk: assert property (@(posedge osc_clk) disable iff (!rst_n)
        data_rdy |-> (track_phase == 2'b00));
endmodule

// File: tb/test_adc_start_gate.sv
module test_adc_start_gate;
    localparam int CLK_PERIOD = 10;
    localparam int STUB_N     = 20;          // stub: rises before eoc goes high
    localparam int CONV_EDGES = STUB_N + 1;  // rises per release until eoc falls

    logic       osc_clk = 1'b0;
    logic       rst_n   = 1'b0;
    logic       start_n = 1'b1;
    logic       adc_eoc = 1'b0;
    logic       adc_clk;
    logic       data_rdy;
    logic [1:0] track_phase;

    int n_checks = 0;
    int n_fails  = 0;
    int exp_q[$];
    int rise_cnt = 0;
    int stub_cnt = 0;
    time t_rise  = 0;

    adc_start_gate i_adc_start_gate (
        .osc_clk     (osc_clk),
        .rst_n       (rst_n),
        .start_n     (start_n),
        .adc_eoc     (adc_eoc),
        .adc_clk     (adc_clk),
        .data_rdy    (data_rdy),
        .track_phase (track_phase)
    );

    always #(CLK_PERIOD/2) osc_clk = ~osc_clk;

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    endtask

    // Converter stub: eoc high after STUB_N rises, falls on the next rise.
    always @(posedge adc_clk) begin
        if (adc_eoc) begin
            adc_eoc  <= 1'b0;
            stub_cnt <= 0;
        end else if (stub_cnt == STUB_N - 1)
            adc_eoc <= 1'b1;
        else
            stub_cnt <= stub_cnt + 1;
    end

    // Scoreboard monitor: edges per conversion compared at data_rdy rise (R5).
    always @(posedge adc_clk) rise_cnt++;
    always @(posedge data_rdy) begin
        if (exp_q.size() > 0)
            chk("R5", "converter edges per release", rise_cnt, exp_q.pop_front());
        rise_cnt = 0;
    end

    // High-pulse width monitor (R7, R1).
    always @(posedge adc_clk) t_rise = $time;
    always @(negedge adc_clk)
        if (rst_n) chk("R7", "adc_clk high time", int'($time - t_rise), CLK_PERIOD);

    // Watchdog.
    initial begin
        repeat (100000) @(posedge osc_clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    task automatic push_exp(input int e);
        exp_q.push_back(e);
    endtask

    task automatic count_toggles(input int n, output int t);
        logic prev;
        t = 0;
        prev = adc_clk;
        for (int i = 0; i < n; i++) begin
            @(negedge osc_clk);
            if (adc_clk != prev) t++;
            prev = adc_clk;
        end
    endtask

    task automatic wait_rdy();
        wait (data_rdy == 1'b1);
        @(negedge osc_clk);
    endtask

    task automatic check_locked(input string req);
        int t;
        count_toggles(60, t);
        chk(req, "edges while locked", t, 0);
        chk("R3", "data_rdy while locked", int'(data_rdy), 1);
        chk("R3", "phase while locked", int'(track_phase), 0);
        chk("R7", "adc_clk level while locked", int'(adc_clk), 0);
    endtask

    task automatic release_and_check_phase(input int low_cycles);
        push_exp(CONV_EDGES);
        fork
            begin
                @(negedge osc_clk);
                start_n = 1'b0;
                repeat (low_cycles) @(negedge osc_clk);
                start_n = 1'b1;
                if (low_cycles == 2) begin
                    chk("R4", "data_rdy after start", int'(data_rdy), 0);
                    chk("R4", "first adc_clk rise", int'(adc_clk), 1);
                end
            end
            begin
                repeat (14) @(posedge adc_clk);
                @(negedge osc_clk);
                @(negedge osc_clk);
                chk("R9", "phase after 14 edges", int'(track_phase), 1);
                @(posedge adc_clk);
                @(negedge osc_clk);
                @(negedge osc_clk);
                chk("R9", "phase after 15 edges", int'(track_phase), 2);
            end
        join
    endtask

    initial begin
        int t;
        bit saw_rdy;
        // Reset state (R8).
        repeat (5) @(negedge osc_clk);
        chk("R8", "adc_clk in reset", int'(adc_clk), 0);
        chk("R8", "data_rdy in reset", int'(data_rdy), 0);
        chk("R8", "phase in reset", int'(track_phase), 1);
        push_exp(CONV_EDGES);
        rst_n = 1'b1;
        count_toggles(10, t);
        chk("R1", "toggles after reset", t, 10);

        // First conversion ends and locks (R2, R3).
        wait_rdy();
        check_locked("R2");

        // Short start pulse: one conversion, then lock again (R4, R5, R9).
        release_and_check_phase(2);
        wait_rdy();
        check_locked("R5");

        // One-cycle pulse also gives exactly one conversion (R5).
        release_and_check_phase(1);
        wait_rdy();
        check_locked("R5");

        // Calibration: start held low, clock free-runs (R6).
        @(negedge osc_clk);
        start_n = 1'b0;
        repeat (3) @(negedge osc_clk);
        saw_rdy = 1'b0;
        t = 0;
        begin
            logic prev;
            prev = adc_clk;
            for (int i = 0; i < 100; i++) begin
                @(negedge osc_clk);
                if (adc_clk != prev) t++;
                prev = adc_clk;
                if (data_rdy) saw_rdy = 1'b1;
            end
        end
        chk("R6", "toggles during calibration", t, 100);
        chk("R6", "data_rdy during calibration", int'(saw_rdy), 0);
        start_n = 1'b1;
        wait_rdy();
        chk("R2", "locked after calibration", int'(track_phase), 0);

        // Reset while locked (R8).
        rst_n = 1'b0;
        repeat (3) @(negedge osc_clk);
        chk("R8", "data_rdy after reset from lock", int'(data_rdy), 0);
        chk("R8", "phase after reset from lock", int'(track_phase), 1);
        rst_n = 1'b1;
        count_toggles(10, t);
        chk("R8", "clock runs after reset from lock", t, 10);

        finish_run();
    end
endmodule